// File: doc/BRIEF.md
# Product-Term Steering Function Block

This block is one logic cluster of a programmable-logic fabric. A shared bus of input signals feeds an AND array in both true and inverted form. Each of several macrocells owns a small group of product terms. A per-term routing word keeps a term at home, or lends it to the macrocell directly above or directly below. Each macrocell ORs every term steered to it into a sum. The sum passes through a polarity stage and then leaves either straight away or through a flip-flop. All flip-flops share one clock and one global set/reset.

Some routing words name more than one destination for a single term. The block settles each such case with a fixed priority and records the fault in a sticky flag. The flag is kept by a two-state tracker: `FLT_CLEAN` (no fault seen) and `FLT_LATCHED` (a fault has been seen). Its transitions are DETECT (`FLT_CLEAN` to `FLT_LATCHED` on a clock edge while a conflict is present), IDLE (`FLT_CLEAN` stays put), HOLD (`FLT_LATCHED` stays put) and CLEAR (global set/reset forces `FLT_CLEAN` at any time).

Top module: `pterm_fblock`

## Requirements
- R1: Term k (macrocell k/5, slot k%5) is the AND of its selected literals. Bit k*72+i of `and_cfg` selects input i in true form, and bit k*72+36+i selects input i in inverted form. A term with no literal selected is 1.
- R2: A macrocell's sum is the OR of every term steered to it. A macrocell that receives no term, including one that has lent out all of its own terms, has a sum of 0.
- R3: The three bits `route_cfg[k*3 +: 3]` steer term k. Bit 0 keeps the term at its own macrocell m, bit 1 sends it to m-1 and bit 2 sends it to m+1. All bits clear leaves the term unused.
- R4: When more than one valid destination bit is set, the term goes only to the lowest-indexed destination: above, then own, then below.
- R5: A conflict present at a clock edge sets `cfg_err` after that edge. `cfg_err` then stays 1 until global set/reset.
- R6: A destination bit that points past the first or last macrocell is ignored. It neither steers the term nor counts toward a conflict.
- R7: With `reg_mode[m]`=0, `mc_out[m]` equals sum XOR `pol_inv[m]` in the same cycle.
- R8: With `reg_mode[m]`=1, `mc_out[m]` shows the value of sum XOR `pol_inv[m]` captured at the previous rising clock edge.
- R9: While `gsr` is 1, every macrocell flip-flop holds `init_val[m]` and `cfg_err` is 0. This takes effect without waiting for a clock edge.
- R10: `mc_oe[m]` equals `oe_cfg[m]` AND `oe_global`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for all macrocell flip-flops and the fault tracker |
| gsr | input | 1 | Global set/reset, asynchronous, active high |
| in_bus | input | 36 | Shared inputs to the AND array |
| and_cfg | input | 6480 | Literal selects, 72 bits per term (true half low, inverted half high) |
| route_cfg | input | 270 | Steering bits, 3 per term |
| reg_mode | input | 18 | Per macrocell: 1 = registered output, 0 = combinational |
| pol_inv | input | 18 | Per macrocell: invert the sum |
| init_val | input | 18 | Per macrocell flip-flop value under global set/reset |
| oe_cfg | input | 18 | Per macrocell output-enable select |
| oe_global | input | 1 | Global output-enable gate |
| mc_out | output | 18 | Macrocell outputs |
| mc_oe | output | 18 | Macrocell output enables |
| cfg_err | output | 1 | Sticky steering-conflict flag |

## Verification
Assertions check the fault flag on every clock edge: it rises after any conflict, it never drops while reset is inactive, and it reads 0 under global set/reset. On every edge they also check that a registered output shows the value captured one edge earlier, and that no enable is driven while the global enable is low. The bench's reference model is the only thing that can show the steering itself. That covers which terms reach which sum, the priority chosen on a double assignment, the off-edge bits being ignored, and a macrocell that gave its terms away reading 0. The model compares every output on every cycle across the random and directed routing scenarios.

// File: rtl/pterm_fb_pkg.sv
`timescale 1ns/1ps
package pterm_fb_pkg;

    // Steering bit positions inside each 3-bit route field
    localparam int ROUTE_W = 3;
    localparam int RT_OWN  = 0;
    localparam int RT_UP   = 1;   // toward lower macrocell index
    localparam int RT_DN   = 2;   // toward higher macrocell index

    typedef enum logic {
        FLT_CLEAN   = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_t;

endpackage

// File: rtl/pterm_and_array.sv
`timescale 1ns/1ps
module pterm_and_array #(
    parameter int N_IN    = 36,
    parameter int N_TERMS = 90,
    localparam int TERM_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]           in_bus,
    input  logic [N_TERMS*TERM_W-1:0] and_cfg,
    output logic [N_TERMS-1:0]        term_val
);

    for (genvar k = 0; k < N_TERMS; k++) begin : g_term
        logic [N_IN-1:0] sel_true;
        logic [N_IN-1:0] sel_comp;
        assign sel_true = and_cfg[k*TERM_W +: N_IN];
        assign sel_comp = and_cfg[k*TERM_W + N_IN +: N_IN];
        // A literal that is not selected contributes a 1 to the AND
        assign term_val[k] = (&(~sel_true | in_bus)) & (&(~sel_comp | ~in_bus));
    end

endmodule

// File: rtl/pterm_steer.sv
`timescale 1ns/1ps
module pterm_steer
    import pterm_fb_pkg::*;
#(
    parameter int N_MC = 18,
    parameter int N_PT = 5,
    localparam int N_TERMS = N_MC * N_PT
) (
    input  logic [N_TERMS-1:0]         term_val,
    input  logic [N_TERMS*ROUTE_W-1:0] route_cfg,
    output logic [N_MC-1:0]            sum_out,
    output logic                       conflict
);

    logic [N_TERMS-1:0] g_up;
    logic [N_TERMS-1:0] g_own;
    logic [N_TERMS-1:0] g_dn;
    logic [N_TERMS-1:0] bad;

    for (genvar k = 0; k < N_TERMS; k++) begin : g_alloc
        localparam int M = k / N_PT;
        logic [ROUTE_W-1:0] eff;

        // Drop destinations that fall off either end of the block
        always_comb begin
            eff = route_cfg[k*ROUTE_W +: ROUTE_W];
            if (M == 0)        eff[RT_UP] = 1'b0;
            if (M == N_MC - 1) eff[RT_DN] = 1'b0;
        end

        // Fixed priority: lowest-indexed destination wins
        assign g_up[k]  = eff[RT_UP];
        assign g_own[k] = eff[RT_OWN] & ~eff[RT_UP];
        assign g_dn[k]  = eff[RT_DN] & ~eff[RT_UP] & ~eff[RT_OWN];
        assign bad[k]   = ($countones(eff) > 1);
    end

    always_comb begin
        sum_out = '0;
        for (int k = 0; k < N_TERMS; k++) begin
            int m;
            m = k / N_PT;
            if (g_own[k])
                sum_out[m] = sum_out[m] | term_val[k];
            if (g_up[k] && m > 0)
                sum_out[m-1] = sum_out[m-1] | term_val[k];
            if (g_dn[k] && m < N_MC - 1)
                sum_out[m+1] = sum_out[m+1] | term_val[k];
        end
    end

    assign conflict = |bad;

endmodule

// File: rtl/pterm_fault_fsm.sv
`timescale 1ns/1ps
module pterm_fault_fsm
    import pterm_fb_pkg::*;
(
    input  logic clk,
    input  logic gsr,
    input  logic conflict,
    output logic cfg_err
);

    flt_state_t state_q;
    flt_state_t state_d;

    // Next-state selection: DETECT, IDLE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAN:   if (conflict) state_d = FLT_LATCHED;
            FLT_LATCHED: state_d = FLT_LATCHED;
            default:     state_d = FLT_CLEAN;
        endcase
    end

    // State register; CLEAR on global set/reset
    always_ff @(posedge clk or posedge gsr) begin
        if (gsr) state_q <= FLT_CLEAN;
        else     state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            FLT_LATCHED: cfg_err = 1'b1;
            default:     cfg_err = 1'b0;
        endcase
    end

    a_r5_err_sets: assert property (@(posedge clk) disable iff (gsr)
        conflict |=> cfg_err);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (gsr)
        cfg_err |=> cfg_err);

    a_r9_gsr_clears_err: assert property (@(posedge clk)
        gsr |-> !cfg_err);

endmodule

// File: rtl/pterm_macrocell.sv
`timescale 1ns/1ps
module pterm_macrocell (
    input  logic clk,
    input  logic gsr,
    input  logic sum,
    input  logic reg_mode,
    input  logic pol_inv,
    input  logic init_val,
    input  logic oe_cfg,
    input  logic oe_global,
    output logic mc_q,
    output logic mc_oe
);

    logic d_val;
    logic q_val;

    assign d_val = sum ^ pol_inv;

    always_ff @(posedge clk or posedge gsr) begin
        if (gsr) q_val <= init_val;
        else     q_val <= d_val;
    end

    assign mc_q  = reg_mode ? q_val : d_val;
    assign mc_oe = oe_cfg & oe_global;

    a_r8_reg_shows_last: assert property (@(posedge clk) disable iff (gsr)
        (reg_mode && !$past(gsr)) |-> (mc_q == $past(d_val)));

    a_r10_oe_gated: assert property (@(posedge clk) disable iff (gsr)
        mc_oe |-> oe_global);

endmodule

// File: rtl/pterm_fblock.sv
`timescale 1ns/1ps
module pterm_fblock
    import pterm_fb_pkg::*;
#(
    parameter int N_IN = 36,
    parameter int N_MC = 18,
    parameter int N_PT = 5,
    localparam int N_TERMS = N_MC * N_PT,
    localparam int AND_W   = N_TERMS * 2 * N_IN,
    localparam int RT_W    = N_TERMS * ROUTE_W
) (
    input  logic             clk,
    input  logic             gsr,
    input  logic [N_IN-1:0]  in_bus,
    input  logic [AND_W-1:0] and_cfg,
    input  logic [RT_W-1:0]  route_cfg,
    input  logic [N_MC-1:0]  reg_mode,
    input  logic [N_MC-1:0]  pol_inv,
    input  logic [N_MC-1:0]  init_val,
    input  logic [N_MC-1:0]  oe_cfg,
    input  logic             oe_global,
    output logic [N_MC-1:0]  mc_out,
    output logic [N_MC-1:0]  mc_oe,
    output logic             cfg_err
);

    logic [N_TERMS-1:0] term_val;
    logic [N_MC-1:0]    sum_vec;
    logic               conflict;

    pterm_and_array #(
        .N_IN    (N_IN),
        .N_TERMS (N_TERMS)
    ) u_and (
        .in_bus   (in_bus),
        .and_cfg  (and_cfg),
        .term_val (term_val)
    );

    pterm_steer #(
        .N_MC (N_MC),
        .N_PT (N_PT)
    ) u_steer (
        .term_val  (term_val),
        .route_cfg (route_cfg),
        .sum_out   (sum_vec),
        .conflict  (conflict)
    );

    pterm_fault_fsm u_fault (
        .clk      (clk),
        .gsr      (gsr),
        .conflict (conflict),
        .cfg_err  (cfg_err)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        pterm_macrocell u_mc (
            .clk       (clk),
            .gsr       (gsr),
            .sum       (sum_vec[m]),
            .reg_mode  (reg_mode[m]),
            .pol_inv   (pol_inv[m]),
            .init_val  (init_val[m]),
            .oe_cfg    (oe_cfg[m]),
            .oe_global (oe_global),
            .mc_q      (mc_out[m]),
            .mc_oe     (mc_oe[m])
        );
    end

endmodule

// File: tb/test_pterm_fblock.sv
`timescale 1ns/1ps
module test_pterm_fblock;

    localparam int NI = 36;
    localparam int NM = 18;
    localparam int NP = 5;
    localparam int NT = NM * NP;
    localparam int TW = 2 * NI;

    logic              clk = 1'b0;
    logic              gsr = 1'b1;
    logic [NI-1:0]     in_bus = '0;
    logic [NT*TW-1:0]  and_cfg = '0;
    logic [NT*3-1:0]   route_cfg = '0;
    logic [NM-1:0]     reg_mode = '0;
    logic [NM-1:0]     pol_inv = '0;
    logic [NM-1:0]     init_val = '0;
    logic [NM-1:0]     oe_cfg = '0;
    logic              oe_global = 1'b0;
    logic [NM-1:0]     mc_out;
    logic [NM-1:0]     mc_oe;
    logic              cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [NM-1:0] model_q = '0;
    bit            model_err = 0;

    always #2.5 clk = ~clk;

    pterm_fblock i_pterm_fblock (
        .clk(clk), .gsr(gsr), .in_bus(in_bus), .and_cfg(and_cfg),
        .route_cfg(route_cfg), .reg_mode(reg_mode), .pol_inv(pol_inv),
        .init_val(init_val), .oe_cfg(oe_cfg), .oe_global(oe_global),
        .mc_out(mc_out), .mc_oe(mc_oe), .cfg_err(cfg_err)
    );

    // ---------------- behavioural reference ----------------
    function automatic bit term_v(int k);
        for (int i = 0; i < NI; i++) begin
            if (and_cfg[k*TW + i] && !in_bus[i]) return 1'b0;
            if (and_cfg[k*TW + NI + i] && in_bus[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int dest(int k);
        int m = k / NP;
        logic [2:0] r = route_cfg[k*3 +: 3];
        if (r[1] && m > 0) return m - 1;
        if (r[0]) return m;
        if (r[2] && m < NM - 1) return m + 1;
        return -1;
    endfunction

    function automatic bit any_conflict();
        for (int k = 0; k < NT; k++) begin
            int m = k / NP;
            logic [2:0] r = route_cfg[k*3 +: 3];
            int cnt = 0;
            if (r[0]) cnt++;
            if (r[1] && m > 0) cnt++;
            if (r[2] && m < NM - 1) cnt++;
            if (cnt > 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit sum_of(int m);
        for (int k = 0; k < NT; k++)
            if (dest(k) == m && term_v(k)) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk or posedge gsr) begin
        if (gsr) begin
            model_q = init_val;
            model_err = 0;
        end else begin
            for (int m = 0; m < NM; m++) model_q[m] = sum_of(m) ^ pol_inv[m];
            if (any_conflict()) model_err = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        logic [NM-1:0] eo;
        for (int m = 0; m < NM; m++)
            eo[m] = reg_mode[m] ? model_q[m] : (sum_of(m) ^ pol_inv[m]);
        chk(mc_out === eo, {tag, " mc_out"}, 64'(mc_out), 64'(eo));
        chk(mc_oe === (oe_cfg & {NM{oe_global}}), "R10 mc_oe",
            64'(mc_oe), 64'(oe_cfg & {NM{oe_global}}));
        chk(cfg_err === model_err, {tag, " cfg_err"}, 64'(cfg_err), 64'(model_err));
    endtask

    // Inputs change just after a falling edge; compare 1 ns later
    task automatic step(string tag);
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    function automatic logic [NT*TW-1:0] rand_and(int lits);
        logic [NT*TW-1:0] v = '0;
        for (int k = 0; k < NT; k++)
            for (int j = 0; j < lits; j++)
                v[k*TW + (($urandom % 2) * NI) + ($urandom % NI)] = 1'b1;
        return v;
    endfunction

    function automatic logic [NT*3-1:0] rand_route();
        logic [NT*3-1:0] v = '0;
        for (int k = 0; k < NT; k++) begin
            int c = $urandom % 4;
            v[k*3 +: 3] = (c == 3) ? 3'b000 : 3'(1 << c);
        end
        return v;
    endfunction

    function automatic logic [NT*3-1:0] all_own();
        logic [NT*3-1:0] v = '0;
        for (int k = 0; k < NT; k++) v[k*3 +: 3] = 3'b001;
        return v;
    endfunction

    initial begin
        init_val = 18'h2A5C3;
        reg_mode = '1;
        oe_cfg   = 18'h0F0F0;
        repeat (2) @(negedge clk);

        // R9: reset state
        #1;
        chk(mc_out === init_val, "R9 reset mc_out", 64'(mc_out), 64'(init_val));
        chk(cfg_err === 1'b0, "R9 reset cfg_err", 64'(cfg_err), 64'd0);
        @(negedge clk);
        gsr = 1'b0;

        // R2: nothing routed -> every sum 0, output equals polarity bit
        reg_mode = '0; route_cfg = '0; and_cfg = '0; pol_inv = 18'h1B3C5;
        #1;
        chk(mc_out === pol_inv, "R2 empty sums", 64'(mc_out), 64'(pol_inv));
        @(negedge clk);

        // R1, R3, R7: own routing, random literals, combinational
        pol_inv = '0; route_cfg = all_own(); and_cfg = rand_and(2);
        oe_global = 1'b1;
        for (int c = 0; c < 40; c++) begin
            in_bus = {$urandom, $urandom};
            step("R1/R3/R7 own");
        end

        // R1: empty terms evaluate to 1
        and_cfg = '0;
        #1;
        chk(mc_out === '1, "R1 empty term", 64'(mc_out), 64'h3FFFF);
        @(negedge clk);

        // R2: macrocell 5 lends all its terms upward, receives nothing
        route_cfg = all_own();
        for (int p = 0; p < NP; p++) route_cfg[(5*NP+p)*3 +: 3] = 3'b010;
        for (int p = 0; p < NP; p++) route_cfg[(4*NP+p)*3 +: 3] = 3'b001;
        for (int p = 0; p < NP; p++) route_cfg[(6*NP+p)*3 +: 3] = 3'b001;
        #1;
        chk(mc_out[5] === 1'b0, "R2 lent-out macrocell", 64'(mc_out[5]), 64'd0);
        chk(mc_out[4] === 1'b1, "R3 borrowed sum", 64'(mc_out[4]), 64'd1);
        @(negedge clk);

        // R3, R8: random one-hot routing, mixed modes
        and_cfg = rand_and(2);
        for (int c = 0; c < 60; c++) begin
            in_bus = {$urandom, $urandom};
            reg_mode = 18'($urandom); pol_inv = 18'($urandom);
            if (c % 10 == 0) route_cfg = rand_route();
            oe_global = c[2];
            step("R3/R8 random routing");
        end

        // R6: off-edge bits on the end macrocells raise no conflict
        route_cfg = all_own();
        route_cfg[0 +: 3] = 3'b011;
        route_cfg[(NT-1)*3 +: 3] = 3'b101;
        and_cfg = '0; reg_mode = '0; pol_inv = '0;
        step("R6 edge bits");
        step("R6 edge bits");
        chk(cfg_err === 1'b0, "R6 no conflict", 64'(cfg_err), 64'd0);

        // R4, R5: term 0 of macrocell 6 assigned both above and own
        route_cfg = '0;
        route_cfg[(6*NP)*3 +: 3] = 3'b011;
        #1;
        chk(mc_out[5] === 1'b1 && mc_out[6] === 1'b0, "R4 lowest index wins",
            64'(mc_out[6:5]), 64'd1);
        chk(cfg_err === 1'b0, "R5 not before edge", 64'(cfg_err), 64'd0);
        @(negedge clk);
        step("R5 flag set");
        route_cfg = all_own();
        for (int c = 0; c < 5; c++) step("R5 sticky");
        chk(cfg_err === 1'b1, "R5 sticky", 64'(cfg_err), 64'd1);

        // R9: global set/reset mid-run, asynchronous
        reg_mode = '1; init_val = 18'h15A3C;
        #1;
        gsr = 1'b1;
        #0.5;
        chk(mc_out === init_val, "R9 async set", 64'(mc_out), 64'(init_val));
        chk(cfg_err === 1'b0, "R9 clears flag", 64'(cfg_err), 64'd0);
        @(negedge clk);
        gsr = 1'b0;
        and_cfg = rand_and(1);
        for (int c = 0; c < 20; c++) begin
            in_bus = {$urandom, $urandom};
            step("R8/R9 after reset");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule